// File: doc/BRIEF.md
# Breakpoint Trap Routing Unit

This unit observes the stream of retired 32-bit instruction words. Each word arrives with the privilege mode that was current when it retired. When a breakpoint instruction retires, the unit picks one of three destinations: a semihosting service request, entry into debug mode, or an ordinary breakpoint exception. Each destination has its own output, and each output gives a one-cycle pulse.

The unit treats a breakpoint specially when it sits between two marker no-ops. The first marker is a shift-left of x0 by 31. The second is an arithmetic shift-right of x0 by 7; its shift amount carries the fixed call number. If the breakpoint is wrapped this way and semihosting is enabled globally, the unit requests semihosting and ignores the per-mode debug enables. In every other case, the debug-enable bit for the mode the breakpoint retired in decides between debug entry and the exception.

Because the closing marker follows the breakpoint, the unit holds each breakpoint until the next retired word, or until a flush, before it decides. A pipeline flush forgets any pending opening marker. It also resolves a held breakpoint without considering semihosting.

Top module: `bkpt_route_unit`

## Requirements
- R1: After synchronous active-low reset, all three outcome pulses are low and no breakpoint is pending. A closing marker retired straight after reset produces no pulse.
- R2: The mode's debug-enable bit is chosen from `dbg_en_i` as follows. Bit 0 is machine (privilege code 3, with `virt_i` ignored). Bit 1 is supervisor (code 1, `virt_i`=0). Bit 2 is user (code 0, `virt_i`=0). Bit 3 is virtual supervisor (code 1, `virt_i`=1). Bit 4 is virtual user (code 0, `virt_i`=1). The bit is sampled in the cycle the breakpoint word (0x00100073) retires.
- R3: If a breakpoint is not routed to semihosting and its mode's enable bit is 1, `dbg_entry_o` pulses for exactly one cycle.
- R4: If a breakpoint is not routed to semihosting and its mode's enable bit is 0, `bkpt_exc_o` pulses for exactly one cycle.
- R5: Suppose the valid word before a breakpoint was 0x01f01013, the next valid word is 0x40705013, there is no flush in between, and `semi_en_i` is 1 in the closing word's cycle. Then `semi_req_o` pulses, whatever the value of `dbg_en_i`.
- R6: When `semi_en_i` is 0, a complete marker sequence is routed by the enable bits as in R3 and R4.
- R7: If either marker is missing around a breakpoint, the enable bits decide the outcome.
- R8: Cycles with `insn_valid_i` low and `flush_i` low change nothing and produce no pulse. The markers and the breakpoint may therefore be separated by idle cycles.
- R9: `flush_i` clears the remembered opening marker and drops any word that retires in the same cycle. If a breakpoint is held, the flush resolves it by R3 or R4, never to semihosting.
- R10: Each breakpoint produces exactly one pulse, and at most one output is high in any cycle. The pulse appears in the cycle after the clock edge that accepts the next valid word or the flush. A breakpoint that directly follows another breakpoint resolves the first one.
- R11: Privilege code 2 is reserved. It selects no enable bit, so a breakpoint retired in it raises the exception unless it is routed to semihosting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid_i | input | 1 | A retired word is present this cycle |
| insn_word_i | input | 32 | Retired instruction word |
| priv_i | input | 2 | Privilege code (3 machine, 1 supervisor, 0 user, 2 reserved) |
| virt_i | input | 1 | Virtualization active |
| dbg_en_i | input | 5 | Per-mode debug-entry enables (bit order in R2) |
| semi_en_i | input | 1 | Global semihosting enable |
| flush_i | input | 1 | Control-flow break; clears detector state |
| semi_req_o | output | 1 | Semihosting request pulse |
| dbg_entry_o | output | 1 | Debug-mode entry pulse |
| bkpt_exc_o | output | 1 | Breakpoint exception pulse |

## Verification
Two things can collide in one cycle: the resolution of a held breakpoint, and a second event that arrives in the same cycle. That event is either a flush or a new breakpoint that becomes held in turn. The bench raises a flush in the same cycle as a valid closing marker. It expects a debug or exception pulse, not a semihosting request, and it checks that the dropped closing word has no later effect. It also retires two breakpoints back to back and expects two exception pulses. The second of these must not inherit the marker status of the first.

// File: rtl/bkpt_route_pkg.sv
// Shared constants and types for the breakpoint trap routing unit.
// Assumes 32-bit instruction words and five privilege/virtualization modes.
package bkpt_route_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_MODES = 5;

    localparam logic [WORD_W-1:0] ENTRY_MARK = 32'h01f01013;
    localparam logic [WORD_W-1:0] BKPT_WORD  = 32'h00100073;
    localparam logic [WORD_W-1:0] CLOSE_MARK = 32'h40705013;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef struct packed {
        logic semi;
        logic dbg;
        logic exc;
    } outcome_t;

    // Privilege code associated with enable-bit index m.
    function automatic logic [1:0] mode_priv(input int unsigned m);
        case (m)
            0:       return PRV_MACH;
            1, 3:    return PRV_SUPER;
            default: return PRV_USER;
        endcase
    endfunction

    // Virtualization flag required by enable-bit index m.
    function automatic logic mode_virt(input int unsigned m);
        return (m == 3) || (m == 4);
    endfunction

    // True when index m does not care about the virtualization flag.
    function automatic logic mode_any_virt(input int unsigned m);
        return (m == 0);
    endfunction

endpackage

// File: rtl/bkpt_mode_sel.sv
// Picks the debug-enable bit that belongs to the current privilege mode.
// Assumes the enable vector is ordered by the index mapping in the package;
// the reserved privilege code matches no index and yields zero.
module bkpt_mode_sel
    import bkpt_route_pkg::*;
#(
    parameter int unsigned N_MODES = NUM_MODES
) (
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    input  logic [N_MODES-1:0] en_i,
    output logic [N_MODES-1:0] hit_o,
    output logic               dbg_on_o
);

    // One comparator per mode index.
    generate
        for (genvar m = 0; m < N_MODES; m++) begin : g_mode
            assign hit_o[m] = (priv_i == mode_priv(m)) &&
                              (mode_any_virt(m) || (virt_i == mode_virt(m)));
        end
    endgenerate

    // The selected bit: OR of enables gated by the matching mode.
    assign dbg_on_o = |(hit_o & en_i);

endmodule

// File: rtl/bkpt_outcome_dec.sv
// Combinational choice of destination for a held breakpoint.
// Assumes the caller only latches the result when a breakpoint is held.
module bkpt_outcome_dec
    import bkpt_route_pkg::*;
(
    input  logic     held_marked_i,
    input  logic     held_dbg_i,
    input  logic     close_hit_i,
    input  logic     semi_en_i,
    input  logic     flush_i,
    output outcome_t out_o
);

    logic semi_take;

    // Semihosting only wins on an unflushed, fully marked sequence.
    always_comb begin
        semi_take  = !flush_i && semi_en_i && held_marked_i && close_hit_i;
        out_o.semi = semi_take;
        out_o.dbg  = !semi_take && held_dbg_i;
        out_o.exc  = !semi_take && !held_dbg_i;
    end

endmodule

// File: rtl/bkpt_seq_tracker.sv
// Holds the opening-marker flag and the pending breakpoint, and registers
// the outcome pulse. Assumes flush takes priority over a same-cycle word.
module bkpt_seq_tracker
    import bkpt_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     valid_i,
    input  logic     flush_i,
    input  logic     entry_hit_i,
    input  logic     bkpt_hit_i,
    input  logic     dbg_on_i,
    input  outcome_t dec_i,
    output logic     held_o,
    output logic     held_marked_o,
    output logic     held_dbg_o,
    output outcome_t pulse_o
);

    logic prev_entry;

    // Advance detector state on valid words; resolve on next word or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_entry    <= 1'b0;
            held_o        <= 1'b0;
            held_marked_o <= 1'b0;
            held_dbg_o    <= 1'b0;
            pulse_o       <= '0;
        end else begin
            pulse_o <= '0;
            if (flush_i) begin
                if (held_o) pulse_o <= dec_i;
                held_o     <= 1'b0;
                prev_entry <= 1'b0;
            end else if (valid_i) begin
                if (held_o) pulse_o <= dec_i;
                prev_entry    <= entry_hit_i;
                held_o        <= bkpt_hit_i;
                held_marked_o <= prev_entry;
                held_dbg_o    <= dbg_on_i;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !flush_i) |=> (pulse_o == '0)); // R8
    AST_ONE_PER_BKPT: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && (valid_i || flush_i)) |=> ($countones(pulse_o) == 1)); // R10
    AST_NO_HELD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !held_o |=> (pulse_o == '0)); // R10
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !held_o); // R9

endmodule

// File: rtl/bkpt_route_unit.sv
// Top of the breakpoint trap routing unit. Decodes marker and breakpoint
// words, selects the mode's debug enable, and drives three outcome pulses.
// Assumes one retired word per cycle at most, qualified by insn_valid_i.
module bkpt_route_unit
    import bkpt_route_pkg::*;
#(
    parameter int unsigned W_WORD  = WORD_W,
    parameter int unsigned N_MODES = NUM_MODES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_valid_i,
    input  logic [W_WORD-1:0]  insn_word_i,
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    input  logic [N_MODES-1:0] dbg_en_i,
    input  logic               semi_en_i,
    input  logic               flush_i,
    output logic               semi_req_o,
    output logic               dbg_entry_o,
    output logic               bkpt_exc_o
);

    localparam logic [W_WORD-1:0] ENTRY_W = W_WORD'(ENTRY_MARK);
    localparam logic [W_WORD-1:0] BKPT_W  = W_WORD'(BKPT_WORD);
    localparam logic [W_WORD-1:0] CLOSE_W = W_WORD'(CLOSE_MARK);

    logic               entry_hit, bkpt_hit, close_hit;
    logic [N_MODES-1:0] mode_hit;
    logic               dbg_on;
    logic               held, held_marked, held_dbg;
    outcome_t           dec, pulse;

    // Word pattern decode.
    always_comb begin
        entry_hit = (insn_word_i == ENTRY_W);
        bkpt_hit  = (insn_word_i == BKPT_W);
        close_hit = (insn_word_i == CLOSE_W);
    end

    bkpt_mode_sel #(.N_MODES(N_MODES)) mode_sel_i (
        .priv_i   (priv_i),
        .virt_i   (virt_i),
        .en_i     (dbg_en_i),
        .hit_o    (mode_hit),
        .dbg_on_o (dbg_on)
    );

    bkpt_outcome_dec outcome_dec_i (
        .held_marked_i (held_marked),
        .held_dbg_i    (held_dbg),
        .close_hit_i   (close_hit),
        .semi_en_i     (semi_en_i),
        .flush_i       (flush_i),
        .out_o         (dec)
    );

    bkpt_seq_tracker tracker_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_i       (insn_valid_i),
        .flush_i       (flush_i),
        .entry_hit_i   (entry_hit),
        .bkpt_hit_i    (bkpt_hit),
        .dbg_on_i      (dbg_on),
        .dec_i         (dec),
        .held_o        (held),
        .held_marked_o (held_marked),
        .held_dbg_o    (held_dbg),
        .pulse_o       (pulse)
    );

    // Drive the outcome ports from the registered pulse.
    assign semi_req_o  = pulse.semi;
    assign dbg_entry_o = pulse.dbg;
    assign bkpt_exc_o  = pulse.exc;

    AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({semi_req_o, dbg_entry_o, bkpt_exc_o})); // R10
    AST_MODE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_hit)); // R2
    AST_SEMI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid_i && !flush_i && !semi_en_i) |=> !semi_req_o); // R6
    AST_FLUSH_NO_SEMI: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !semi_req_o); // R9
    AST_RSVD_NO_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid_i && !flush_i && bkpt_hit && priv_i == PRV_RSVD) |=> !held_dbg); // R11

endmodule

// File: tb/bkpt_route_unit_tb_top.sv
// Self-checking bench: full sweep of mode, virtualization, enables,
// semihosting enable and marker presence, plus directed corner cases.
module bkpt_route_unit_tb_top;

    localparam logic [31:0] ENT  = 32'h01f01013;
    localparam logic [31:0] BKP  = 32'h00100073;
    localparam logic [31:0] CLS  = 32'h40705013;
    localparam logic [31:0] NOPW = 32'h00000013;
    localparam logic [2:0]  NONE = 3'b000;
    localparam logic [2:0]  SEMI = 3'b100;
    localparam logic [2:0]  DBG  = 3'b010;
    localparam logic [2:0]  EXC  = 3'b001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic [1:0]  priv = 2'd3;
    logic        virt = 1'b0;
    logic [4:0]  dbg_en = '0;
    logic        semi_en = 1'b0;
    logic        flush = 1'b0;
    logic        semi_req, dbg_entry, bkpt_exc;
    logic [2:0]  got;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    bkpt_route_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .insn_valid_i (insn_valid),
        .insn_word_i  (insn_word),
        .priv_i       (priv),
        .virt_i       (virt),
        .dbg_en_i     (dbg_en),
        .semi_en_i    (semi_en),
        .flush_i      (flush),
        .semi_req_o   (semi_req),
        .dbg_entry_o  (dbg_entry),
        .bkpt_exc_o   (bkpt_exc)
    );

    task automatic step(input logic v, input logic [31:0] w, input logic f);
        @(negedge clk);
        insn_valid = v;
        insn_word  = w;
        flush      = f;
        @(posedge clk);
        #1;
        got = {semi_req, dbg_entry, bkpt_exc};
    endtask

    task automatic check(input string req, input logic [2:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (semi,dbg,exc)", req, got, exp);
        end
    endtask

    function automatic logic sel_bit(input logic [1:0] p, input logic vz,
                                     input logic [4:0] en);
        case (p)
            2'd3:    return en[0];
            2'd1:    return vz ? en[3] : en[1];
            2'd0:    return vz ? en[4] : en[2];
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] exp;
        string      tag;
        repeat (3) step(1'b0, NOPW, 1'b0);
        check("R1 reset outputs", NONE);
        rst_n = 1'b1;
        step(1'b1, CLS, 1'b0);
        check("R1 close after reset", NONE);

        // Sweep all small configurations.
        for (int p = 0; p < 4; p++) begin
            for (int vz = 0; vz < 2; vz++) begin
                for (int en = 0; en < 32; en++) begin
                    for (int s = 0; s < 2; s++) begin
                        for (int pat = 0; pat < 4; pat++) begin
                            priv    = 2'(p);
                            virt    = vz[0];
                            dbg_en  = 5'(en);
                            semi_en = s[0];
                            step(1'b1, pat[0] ? ENT : NOPW, 1'b0);
                            check("R10 quiet before bkpt", NONE);
                            step(1'b1, BKP, 1'b0);
                            check("R10 held until next word", NONE);
                            step(1'b1, pat[1] ? CLS : NOPW, 1'b0);
                            if (s == 1 && pat == 3) begin
                                exp = SEMI; tag = "R5 marked semihost";
                            end else begin
                                exp = sel_bit(2'(p), vz[0], 5'(en)) ? DBG : EXC;
                                if (p == 2)        tag = "R11 reserved mode";
                                else if (pat == 3) tag = "R6 semihost off";
                                else if (pat != 0) tag = "R7 partial marker";
                                else if (exp == DBG) tag = "R2 R3 debug entry";
                                else               tag = "R2 R4 exception";
                            end
                            check(tag, exp);
                        end
                    end
                end
            end
        end

        // R8: idle gaps inside the marker sequence.
        priv = 2'd3; virt = 1'b0; dbg_en = 5'h1f; semi_en = 1'b1;
        step(1'b1, ENT, 1'b0);
        repeat (3) begin step(1'b0, BKP, 1'b0); check("R8 idle quiet", NONE); end
        step(1'b1, BKP, 1'b0);
        repeat (3) begin step(1'b0, CLS, 1'b0); check("R8 idle holds", NONE); end
        step(1'b1, CLS, 1'b0);
        check("R8 gapped sequence", SEMI);

        // R9: flush forgets the opening marker.
        step(1'b1, ENT, 1'b0);
        step(1'b0, NOPW, 1'b1);
        check("R9 flush no held", NONE);
        step(1'b1, BKP, 1'b0);
        step(1'b1, CLS, 1'b0);
        check("R9 marker forgotten", DBG);

        // R9: flush coincides with closing marker.
        step(1'b1, ENT, 1'b0);
        step(1'b1, BKP, 1'b0);
        step(1'b1, CLS, 1'b1);
        check("R9 flush with close", DBG);
        step(1'b1, CLS, 1'b0);
        check("R9 dropped word inert", NONE);

        // R9: flush alone resolves held breakpoint to exception.
        dbg_en = 5'h00;
        step(1'b1, ENT, 1'b0);
        step(1'b1, BKP, 1'b0);
        step(1'b0, NOPW, 1'b1);
        check("R9 flush resolves", EXC);

        // R10: back-to-back breakpoints.
        step(1'b1, ENT, 1'b0);
        step(1'b1, BKP, 1'b0);
        step(1'b1, BKP, 1'b0);
        check("R10 first of pair", EXC);
        step(1'b1, CLS, 1'b0);
        check("R10 second unmarked", EXC);

        // R2: enable sampled at breakpoint cycle.
        dbg_en = 5'h01;
        step(1'b1, BKP, 1'b0);
        dbg_en = 5'h00;
        step(1'b1, NOPW, 1'b0);
        check("R2 enable sampled at bkpt", DBG);

        // R1: reset drops a held breakpoint.
        step(1'b1, ENT, 1'b0);
        step(1'b1, BKP, 1'b0);
        rst_n = 1'b0;
        step(1'b0, NOPW, 1'b0);
        rst_n = 1'b1;
        step(1'b1, CLS, 1'b0);
        check("R1 reset clears held", NONE);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule